// File: doc/BRIEF.md
# DDS Serial Register Access Sequencer

This block turns one register access request into a complete serial frame for a direct digital synthesis chip. A request carries a 7-bit register address, a read/write flag, a size flag (one or two data words), a 3-bit encoded chip-select code and up to two 32-bit write words. The block first sends an 8-bit instruction byte, then one or two 32-bit data phases, all within one chip-select assertion. It then raises a one-cycle done pulse and, for reads, presents the captured word.

The serial link runs in SPI mode 0: the serial clock idles low, the input is sampled on rising edges and output bits change on falling edges. Every half period of the serial clock lasts `clk_div + 1` system clocks, and the divider value is captured when a request is accepted. The chip-select output is a binary code, not one-hot. Code 0 means that no device is selected. Codes 4 to 7 address single channels and code 3 addresses a group of channels together. Any other code is refused.

Top module: `dds_reg_seq`

## Requirements
- R1: The first 8 bits of every frame form the instruction byte, sent MSB first: bit 7 is 1 for a read and 0 for a write, and bits 6:0 are `req_addr`.
- R2: A write with `req_wide`=0 is a 40-bit frame: the instruction, then `req_wdata_lo` MSB first.
- R3: A write with `req_wide`=1 is a 72-bit frame: the instruction, then `req_wdata_hi`, then `req_wdata_lo`, each MSB first.
- R4: A read is always a 40-bit frame, whatever `req_wide` holds. Its data phase drives 32 zero bits on `mosi`. `rdata` takes the 32 bits sampled from `miso` on the data-phase rising edges, first bit as MSB, in the same cycle that `done` rises, and holds them until the next read completes.
- R5: `cs_code` equals the accepted `req_cs` from the acceptance edge through the final falling serial-clock edge, stays constant for the whole frame, and is 0 whenever `busy` is low.
- R6: The serial clock follows SPI mode 0: `sclk` is low while idle, and each half period lasts `clk_div`+1 system clocks, counted from the acceptance edge.
- R7: For a frame of N bits and a half period of H clocks, `done` is high for exactly one cycle, after the clock edge that comes 2·N·H edges after the acceptance edge. `busy` is high from the acceptance edge up to that edge and falls together with the rise of `done`.
- R8: A `req_valid` that arrives while `busy` is high is ignored: the running frame is unchanged and no further frame follows.
- R9: A request with `req_cs` equal to 0, 1 or 2 starts no transfer. `err` is high for one cycle after the acceptance edge, while `busy`, `done`, `sclk` and `cs_code` stay at 0.
- R10: Code 3 (group select) is accepted like a single-channel code and is driven on `cs_code` for the whole frame.
- R11: While `rst_n` is low at a clock edge, `busy`, `done`, `err`, `sclk`, `mosi`, `cs_code` and `rdata` go to 0. This also aborts a frame in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request strobe, acted on only when idle |
| req_read | input | 1 | 1 = read, 0 = write |
| req_wide | input | 1 | 1 = two data words (writes only) |
| req_addr | input | 7 | Register address |
| req_cs | input | 3 | Encoded chip-select code, 3 to 7 valid |
| req_wdata_hi | input | 32 | First data word of a wide write |
| req_wdata_lo | input | 32 | Last (or only) write data word |
| clk_div | input | DIV_W | Half-period length minus one, in system clocks |
| busy | output | 1 | Frame in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | One-cycle pulse for a refused chip-select code |
| rdata | output | 32 | Word captured by the last read |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| cs_code | output | 3 | Encoded chip select, 0 when idle |
| miso | input | 1 | Serial data in |

## Verification
The only latency that depends on the request is the completion: `done`, the fall of `busy` and a new `rdata` are due 2·N·(clk_div+1) edges after the acceptance edge. The bench computes this count from the vector and samples one cycle before (still busy, no done) and exactly at it. The refusal pulse `err` is due one edge after acceptance and is checked at that edge and at the next. Frame content and chip-select constancy come from a serial-slave model that records every rising `sclk` edge, so they do not depend on when they are sampled.

// File: rtl/dds_seq_pkg.sv
// Shared constants, types and helpers for the DDS register access sequencer.
// Assumes a 7-bit register address and a 3-bit encoded chip select.
package dds_seq_pkg;
    localparam int INSTR_W  = 8;
    localparam int ADDR_W   = INSTR_W - 1;
    localparam int WORD_W   = 32;
    localparam int CS_W     = 3;
    localparam int CNT_W    = $clog2(WORD_W + 1);
    localparam logic [CS_W-1:0] CS_IDLE  = '0;
    localparam logic [CS_W-1:0] CS_GROUP = 3'd3;

    typedef enum logic [1:0] {
        PH_IDLE,
        PH_INSTR,
        PH_HI,
        PH_LO
    } ph_e;

    // Valid codes are the group code and everything above it.
    function automatic logic cs_valid(input logic [CS_W-1:0] code);
        return (code >= CS_GROUP) && (code != CS_IDLE);
    endfunction
endpackage

// File: rtl/dds_seq_clkdiv.sv
// Half-period tick generator for the serial clock.
// Assumes half_lim is held stable while run is high; the count restarts when run is low.
module dds_seq_clkdiv #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] half_lim,
    output logic             tick
);
    logic [DIV_W-1:0] cnt;

    // Counts 0..half_lim while running; clears while idle.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            cnt <= '0;
        end else if (cnt == half_lim) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    assign tick = run && (cnt == half_lim);
endmodule

// File: rtl/dds_seq_instr_enc.sv
// Builds the instruction phase word: read flag in the top bit, address below,
// left-aligned in a shift word so that it leaves MSB first.
module dds_seq_instr_enc
    import dds_seq_pkg::*;
(
    input  logic              rd,
    input  logic [ADDR_W-1:0] addr,
    output logic [WORD_W-1:0] word
);
    assign word = {rd, addr, {(WORD_W - INSTR_W){1'b0}}};
endmodule

// File: rtl/dds_seq_shifter.sv
// SPI mode 0 shift engine: a rising tick samples miso, a falling tick shifts mosi.
// Assumes the first tick after a load is a rising edge (sclk is cleared on load).
module dds_seq_shifter
    import dds_seq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [WORD_W-1:0] load_word,
    input  logic [CNT_W-1:0]  load_bits,
    input  logic              tick,
    input  logic              miso,
    output logic              sclk,
    output logic              mosi,
    output logic [WORD_W-1:0] rx_word,
    output logic              phase_end
);
    logic [WORD_W-1:0] tx;
    logic [CNT_W-1:0]  left;

    // Loads a phase, or advances one serial-clock half period on a tick.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx      <= '0;
            left    <= '0;
            sclk    <= 1'b0;
            rx_word <= '0;
        end else if (load) begin
            tx   <= load_word;
            left <= load_bits;
            sclk <= 1'b0;
        end else if (tick) begin
            if (!sclk) begin
                sclk    <= 1'b1;
                rx_word <= {rx_word[WORD_W-2:0], miso};
            end else begin
                sclk <= 1'b0;
                tx   <= {tx[WORD_W-2:0], 1'b0};
                left <= left - 1'b1;
            end
        end
    end

    assign mosi      = tx[WORD_W-1];
    assign phase_end = tick && sclk && (left == CNT_W'(1));
endmodule

// File: rtl/dds_reg_seq.sv
// DDS register access sequencer top: accepts one request, runs the instruction
// phase and one or two data phases under one chip-select code, then pulses done.
// Assumes req_* and clk_div are valid in the cycle req_valid is high.
module dds_reg_seq
    import dds_seq_pkg::*;
#(
    parameter int DIV_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_read,
    input  logic              req_wide,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [CS_W-1:0]   req_cs,
    input  logic [WORD_W-1:0] req_wdata_hi,
    input  logic [WORD_W-1:0] req_wdata_lo,
    input  logic [DIV_W-1:0]  clk_div,
    output logic              busy,
    output logic              done,
    output logic              err,
    output logic [WORD_W-1:0] rdata,
    output logic              sclk,
    output logic              mosi,
    output logic [CS_W-1:0]   cs_code,
    input  logic              miso
);
    ph_e               ph;
    logic              rd_q;
    logic              wide_q;
    logic [WORD_W-1:0] hi_q;
    logic [WORD_W-1:0] lo_q;
    logic [CS_W-1:0]   cs_q;
    logic [DIV_W-1:0]  lim_q;
    logic              tick;
    logic              phase_end;
    logic              accept;
    logic              load;
    logic [WORD_W-1:0] instr_word;
    logic [WORD_W-1:0] load_word;
    logic [CNT_W-1:0]  load_bits;
    logic [WORD_W-1:0] rx_word;

    assign busy    = (ph != PH_IDLE);
    assign cs_code = busy ? cs_q : CS_IDLE;
    assign accept  = req_valid && !busy && cs_valid(req_cs);

    dds_seq_instr_enc u_enc (
        .rd   (req_read),
        .addr (req_addr),
        .word (instr_word)
    );

    // Picks the word for the next phase: instruction on accept, then data.
    always_comb begin
        load_word = '0;
        if (accept) begin
            load_word = instr_word;
        end else begin
            case (ph)
                PH_INSTR: load_word = rd_q ? '0 : (wide_q ? hi_q : lo_q);
                PH_HI:    load_word = lo_q;
                default:  load_word = '0;
            endcase
        end
    end

    assign load      = accept || (phase_end && (ph == PH_INSTR || ph == PH_HI));
    assign load_bits = accept ? CNT_W'(INSTR_W) : CNT_W'(WORD_W);

    dds_seq_clkdiv #(.DIV_W(DIV_W)) u_div (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (busy),
        .half_lim (lim_q),
        .tick     (tick)
    );

    dds_seq_shifter u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (load),
        .load_word (load_word),
        .load_bits (load_bits),
        .tick      (tick),
        .miso      (miso),
        .sclk      (sclk),
        .mosi      (mosi),
        .rx_word   (rx_word),
        .phase_end (phase_end)
    );

    // Phase sequencing, request capture and completion/refusal pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ph     <= PH_IDLE;
            rd_q   <= 1'b0;
            wide_q <= 1'b0;
            hi_q   <= '0;
            lo_q   <= '0;
            cs_q   <= CS_IDLE;
            lim_q  <= '0;
            done   <= 1'b0;
            err    <= 1'b0;
            rdata  <= '0;
        end else begin
            done <= 1'b0;
            err  <= 1'b0;
            case (ph)
                PH_IDLE: begin
                    if (accept) begin
                        ph     <= PH_INSTR;
                        rd_q   <= req_read;
                        wide_q <= req_wide && !req_read;
                        hi_q   <= req_wdata_hi;
                        lo_q   <= req_wdata_lo;
                        cs_q   <= req_cs;
                        lim_q  <= clk_div;
                    end else if (req_valid) begin
                        err <= 1'b1;
                    end
                end
                PH_INSTR: if (phase_end) ph <= wide_q ? PH_HI : PH_LO;
                PH_HI:    if (phase_end) ph <= PH_LO;
                PH_LO: begin
                    if (phase_end) begin
                        ph   <= PH_IDLE;
                        done <= 1'b1;
                        if (rd_q) rdata <= rx_word;
                    end
                end
                default: ph <= PH_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/dds_seq_checks.sv
// Property checker for dds_reg_seq, attached by bind below.
module dds_seq_checks
    import dds_seq_pkg::*;
(
    input logic            clk,
    input logic            rst_n,
    input logic            req_valid,
    input logic            busy,
    input logic            done,
    input logic            err,
    input logic            sclk,
    input logic [CS_W-1:0] cs_code
);
    a_r5_cs_held: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(cs_code));

    a_r5_cs_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (cs_code == CS_IDLE));

    a_r6_sclk_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !sclk);

    a_r7_done_ends_busy: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && $past(busy)));

    a_r7_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r8_start_needs_valid: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(req_valid));

    a_r9_err_no_frame: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> (!busy && cs_code == CS_IDLE && !done));

    a_r9_err_excl: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({done, err}));
endmodule

bind dds_reg_seq dds_seq_checks u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .busy      (busy),
    .done      (done),
    .err       (err),
    .sclk      (sclk),
    .cs_code   (cs_code)
);

// File: tb/tb_dds_reg_seq.sv
module tb_dds_reg_seq;
    localparam int DIV_W = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_read = 1'b0;
    logic        req_wide = 1'b0;
    logic [6:0]  req_addr = '0;
    logic [2:0]  req_cs = '0;
    logic [31:0] req_wdata_hi = '0;
    logic [31:0] req_wdata_lo = '0;
    logic [7:0]  clk_div = '0;
    logic        busy, done, err, sclk, mosi, miso;
    logic [31:0] rdata;
    logic [2:0]  cs_code;

    int total = 0;
    int bad = 0;

    always #2 clk = ~clk;   // 250 MHz

    dds_reg_seq #(.DIV_W(DIV_W)) dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_read(req_read),
        .req_wide(req_wide), .req_addr(req_addr), .req_cs(req_cs),
        .req_wdata_hi(req_wdata_hi), .req_wdata_lo(req_wdata_lo),
        .clk_div(clk_div), .busy(busy), .done(done), .err(err), .rdata(rdata),
        .sclk(sclk), .mosi(mosi), .cs_code(cs_code), .miso(miso)
    );

    // Serial slave model: records mosi on rising sclk, shifts miso on falling sclk.
    logic [71:0] cap;
    logic [71:0] pat;
    int          nbits;
    logic [2:0]  cs_exp;
    int          cs_bad;
    assign miso = pat[71];

    always @(posedge sclk) begin
        cap   = {cap[70:0], mosi};
        nbits = nbits + 1;
        if (cs_code != cs_exp) cs_bad = cs_bad + 1;
    end
    always @(negedge sclk) pat = {pat[70:0], 1'b0};

    task automatic chk(input bit ok, input string tag, input logic [71:0] act,
                       input logic [71:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic slave_prep(input logic [31:0] rd_word, input logic [2:0] cs);
        cap = '0; nbits = 0; cs_bad = 0; cs_exp = cs;
        pat = {8'h5A, rd_word, 32'h0};
    endtask

    task automatic drive(input bit rd, input bit wide, input logic [6:0] addr,
                         input logic [2:0] cs, input logic [31:0] hi,
                         input logic [31:0] lo, input logic [7:0] div);
        @(negedge clk);
        req_valid = 1'b1; req_read = rd; req_wide = wide; req_addr = addr;
        req_cs = cs; req_wdata_hi = hi; req_wdata_lo = lo; clk_div = div;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    typedef struct packed {
        logic        rd;
        logic        wide;
        logic [6:0]  addr;
        logic [2:0]  cs;
        logic [31:0] hi;
        logic [31:0] lo;
        logic [31:0] rword;
        logic [7:0]  div;
    } vec_t;

    localparam vec_t VECS [6] = '{
        '{1'b0, 1'b0, 7'h07, 3'd4, 32'h0,         32'hDEADBEEF, 32'h0,         8'd0},
        '{1'b0, 1'b1, 7'h0E, 3'd5, 32'h3FFF0000, 32'h12345678, 32'h0,         8'd1},
        '{1'b1, 1'b0, 7'h03, 3'd6, 32'h0,         32'h0,         32'h0000007F, 8'd2},
        '{1'b1, 1'b1, 7'h7F, 3'd7, 32'hFFFFFFFF, 32'hFFFFFFFF, 32'hA5C30F96, 8'd0},
        '{1'b0, 1'b1, 7'h00, 3'd3, 32'h80000001, 32'hFFFFFFFF, 32'h0,         8'd3},
        '{1'b0, 1'b0, 7'h0A, 3'd3, 32'h0,         32'h00000000, 32'h0,         8'd1}
    };

    // Watchdog: counts as a failed check and still reports.
    initial begin
        repeat (150000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [71:0] exp_frame;
        logic [31:0] last_rd;
        int          n_exp;
        int          h;
        int          waited;
        slave_prep(32'h0, 3'd0);
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R11: reset state
        chk({busy, done, err, sclk, mosi, cs_code, rdata} == '0, "R11 reset state",
            {busy, done, err, sclk, mosi, cs_code, rdata}, '0);
        rst_n = 1'b1;
        last_rd = '0;

        // Vector table walk: R1 R2 R3 R4 R5 R6 R7 R10
        for (int i = 0; i < 6; i++) begin
            vec_t v = VECS[i];
            h = int'(v.div) + 1;
            n_exp = (v.rd || !v.wide) ? 40 : 72;
            if (v.rd)        exp_frame = {1'b1, v.addr, 64'h0};
            else if (v.wide) exp_frame = {1'b0, v.addr, v.hi, v.lo};
            else             exp_frame = {1'b0, v.addr, v.lo, 32'h0};
            slave_prep(v.rword, v.cs);
            drive(v.rd, v.wide, v.addr, v.cs, v.hi, v.lo, v.div);
            chk(busy && cs_code == v.cs, "R5 cs after accept", {68'h0, busy, cs_code},
                {68'h0, 1'b1, v.cs});
            repeat (2 * n_exp * h - 1) @(posedge clk);
            @(negedge clk);
            chk(busy && !done, "R7 still busy one cycle before done",
                {70'h0, busy, done}, {70'h0, 2'b10});
            @(posedge clk);
            @(negedge clk);
            chk(!busy && done, "R7 done after 2*N*H edges / R6 half period",
                {70'h0, busy, done}, {70'h0, 2'b01});
            chk(nbits == n_exp, "R2 R3 R4 frame length", 72'(nbits), 72'(n_exp));
            chk((cap << (72 - nbits)) == exp_frame, "R1 R2 R3 R4 frame bits",
                cap << (72 - nbits), exp_frame);
            chk(cs_bad == 0, "R5 R10 cs constant during frame", 72'(cs_bad), 72'h0);
            if (v.rd) last_rd = v.rword;
            chk(rdata == last_rd, "R4 read data", 72'(rdata), 72'(last_rd));
            @(negedge clk);
            chk(!done && cs_code == 3'd0 && !sclk, "R5 R6 R7 idle after frame",
                {68'h0, done, cs_code}, 72'h0);
        end

        // R9: refused chip-select codes 0, 1, 2
        for (int c = 0; c < 3; c++) begin
            slave_prep(32'h0, 3'd0);
            drive(1'b0, 1'b0, 7'h01, 3'(c), 32'h0, 32'h1, 8'd0);
            chk(err && !busy && cs_code == 3'd0, "R9 err pulse on refused code",
                {67'h0, err, busy, cs_code}, {67'h0, 2'b10, 3'd0});
            @(negedge clk);
            chk(!err, "R9 err single cycle", 72'(err), 72'h0);
            repeat (20) @(negedge clk);
            chk(nbits == 0 && !busy && !done, "R9 no transfer", 72'(nbits), 72'h0);
        end

        // R8: request while busy is ignored
        slave_prep(32'h0, 3'd4);
        drive(1'b0, 1'b0, 7'h11, 3'd4, 32'h0, 32'hCAFEF00D, 8'd0);
        repeat (8) @(negedge clk);
        req_valid = 1'b1; req_addr = 7'h22; req_cs = 3'd5; req_wdata_lo = 32'h1;
        @(negedge clk);
        req_valid = 1'b0;
        waited = 0;
        while (!done && waited < 1000) begin @(negedge clk); waited++; end
        chk(nbits == 40 && (cap[39:0] == {8'h11, 32'hCAFEF00D}) && cs_bad == 0,
            "R8 running frame unchanged", {cap[39:0], 32'(nbits)},
            {8'h11, 32'hCAFEF00D, 32'd40});
        repeat (100) @(negedge clk);
        chk(nbits == 40 && !busy, "R8 no second frame", 72'(nbits), 72'd40);

        // R11: reset aborts a frame in progress
        slave_prep(32'h0, 3'd6);
        drive(1'b0, 1'b1, 7'h15, 3'd6, 32'h1, 32'h2, 8'd1);
        repeat (30) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        chk({busy, done, err, sclk, mosi, cs_code, rdata} == '0, "R11 reset mid-frame",
            {busy, done, err, sclk, mosi, cs_code, rdata}, '0);
        rst_n = 1'b1;
        repeat (50) @(negedge clk);
        chk(!busy && !done, "R11 stays idle after reset", {70'h0, busy, done}, 72'h0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule